// File: doc/BRIEF.md
# Banked Latched Interrupt Controller

This block gathers event lines from the functions of a multi-function peripheral chip into one active-high interrupt request for a host processor. The lines are organised in groups of eight. For each group there are three byte-wide registers: a live view of the synchronized input levels, a sticky record of rising edges, and an enable mask. Reading the sticky record acknowledges the events it reports.

The host reaches the registers through a simple synchronous port with a 16-bit address. The upper address byte selects a bank and the lower byte selects a register inside it. The interrupt bank holds three windows: live levels from offset 0x00, sticky records from 0x20 and masks from 0x40. Group numbering inside each window is sparse. The default miscellaneous bank holds a fixed revision byte.

A two-state access sequencer handles the port. In ACC_IDLE no read data is presented. A read request moves it to ACC_REPLY, where data is valid for one cycle. Another read in ACC_REPLY keeps it there. A write, or no request, returns it to ACC_IDLE.

Top module: `evt_irq_hub`

## Requirements
- R1: An address is {bank[15:8], offset[7:0]}. The interrupt bank is 0x0E. The group with window offset k has its live register at 0x00+k, its sticky register at 0x20+k and its mask register at 0x40+k.
- R2: Only window offsets 0,1,2,3,4,6,7,8,9,18,19,20,21 are implemented, assigned to group indices 0..12 in that order. Every other offset in the interrupt bank reads 0x00 and ignores writes.
- R3: Event line L belongs to group index L/8 at bit L mod 8 of that group's registers.
- R4: All mask registers read 0xFF after reset and are writable. A mask bit of 1 keeps its line from raising the interrupt, and 0 lets it through.
- R5: A rising edge on a synchronized event line sets its sticky bit. The bit stays set until it is read, even after the line returns low.
- R6: A read of a sticky register returns its pending bits and clears them.
- R7: An edge that sets a sticky bit in the same cycle as a read of that register leaves the bit set after the read.
- R8: irq_out is a register that holds the OR over all groups of (sticky AND NOT mask) from the previous cycle.
- R9: Live registers return the synchronized input levels. Writes to live or sticky registers have no effect.
- R10: Offset 0x80 of bank MISC_BANK (default 0x10) reads the parameter REV_ID (one of 0x00, 0x10, 0x11; default 0x10). Any address outside the two banks reads 0x00.
- R11: reg_rvalid is 1 exactly in the cycle after a read request, and reg_rdata holds the read data in that cycle. After reset, reg_rvalid, reg_rdata and irq_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | NUM_GROUPS*8 | Asynchronous event lines; line L is bit L |
| reg_req | input | 1 | Access request strobe |
| reg_wr | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 16 | Bank in the upper byte, register offset in the lower byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rvalid is 1 |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq_out | output | 1 | Interrupt request to the host, active high |

## Verification
A table of reads taken straight after reset covers implemented and skipped window offsets in every window, the revision byte, and a foreign bank. These reads separate correct sparse decoding from a linear or shifted group map. Directed sequences then pulse single lines in the first, a middle and the last group. Each such sequence reads the live and sticky views before and after the line falls, which separates edge capture from level following and a correct group/bit split from a wrong one. Masking is tested by opening one mask bit while an event is pending and watching irq_out rise and then fall after acknowledgement. One sequence places an edge in exactly the cycle of a sticky read, to show that clear does not take priority over set.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int unsigned GRP_LINES = 8;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_LIVE,
        RK_STICKY,
        RK_MASK,
        RK_REV
    } reg_kind_e;

    typedef enum logic {
        ACC_IDLE,
        ACC_REPLY
    } acc_state_e;

    // Window offset of group index g: offsets 5 and 10..17 are skipped
    function automatic int unsigned grp_offset(input int unsigned g);
        if (g < 5)
            return g;
        else if (g < 9)
            return g + 1;
        else
            return g + 9;
    endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] level_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q  <= '0;
            level_q <= '0;
            prev_q  <= '0;
        end else begin
            meta_q  <= async_i;
            level_q <= meta_q;
            prev_q  <= level_q;
        end
    end

    assign level_o = level_q;
    assign rise_o  = level_q & ~prev_q;
endmodule

// File: rtl/evt_irq_group.sv
module evt_irq_group #(
    parameter int unsigned LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] rise_i,
    input  logic             clr_i,
    input  logic             mask_we_i,
    input  logic [LINES-1:0] mask_d_i,
    output logic [LINES-1:0] sticky_o,
    output logic [LINES-1:0] mask_o,
    output logic             pend_o
);
    logic [LINES-1:0] sticky_q;
    logic [LINES-1:0] mask_q;
    logic [LINES-1:0] keep;

    // A read clears what it reported; a new edge in the same cycle survives
    assign keep = clr_i ? '0 : sticky_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky_q <= '0;
            mask_q   <= '1;
        end else begin
            sticky_q <= keep | rise_i;
            if (mask_we_i)
                mask_q <= mask_d_i;
        end
    end

    assign sticky_o = sticky_q;
    assign mask_o   = mask_q;
    assign pend_o   = |(sticky_q & ~mask_q);
endmodule

// File: rtl/evt_reg_decode.sv
module evt_reg_decode
    import evt_irq_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 13,
    parameter int unsigned GIDX_W     = 4,
    parameter logic [7:0]  INT_BANK   = 8'h0E,
    parameter logic [7:0]  MISC_BANK  = 8'h10,
    parameter int unsigned LIVE_BASE  = 0,
    parameter int unsigned STKY_BASE  = 32,
    parameter int unsigned MASK_BASE  = 64,
    parameter logic [7:0]  REV_OFF    = 8'h80
) (
    input  logic [15:0]       addr_i,
    output reg_kind_e         kind_o,
    output logic [GIDX_W-1:0] gidx_o
);
    logic [7:0] bank;
    logic [7:0] off;

    assign bank = addr_i[15:8];
    assign off  = addr_i[7:0];

    always_comb begin
        kind_o = RK_NONE;
        gidx_o = '0;
        if (bank == MISC_BANK && off == REV_OFF) begin
            kind_o = RK_REV;
        end else if (bank == INT_BANK) begin
            for (int unsigned g = 0; g < NUM_GROUPS; g++) begin
                if (off == 8'(LIVE_BASE + grp_offset(g))) begin
                    kind_o = RK_LIVE;
                    gidx_o = GIDX_W'(g);
                end
                if (off == 8'(STKY_BASE + grp_offset(g))) begin
                    kind_o = RK_STICKY;
                    gidx_o = GIDX_W'(g);
                end
                if (off == 8'(MASK_BASE + grp_offset(g))) begin
                    kind_o = RK_MASK;
                    gidx_o = GIDX_W'(g);
                end
            end
        end
    end
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
    import evt_irq_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 13,
    parameter logic [7:0]  INT_BANK   = 8'h0E,
    parameter logic [7:0]  MISC_BANK  = 8'h10,
    parameter logic [7:0]  REV_ID     = 8'h10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_GROUPS*GRP_LINES-1:0] evt_in,
    input  logic                            reg_req,
    input  logic                            reg_wr,
    input  logic [15:0]                     reg_addr,
    input  logic [7:0]                      reg_wdata,
    output logic [7:0]                      reg_rdata,
    output logic                            reg_rvalid,
    output logic                            irq_out
);
    localparam int unsigned NLINES = NUM_GROUPS * GRP_LINES;
    localparam int unsigned GIDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

    logic [NLINES-1:0]     lvl_all;
    logic [NLINES-1:0]     rise_all;
    logic [NLINES-1:0]     lat_all;
    logic [NLINES-1:0]     msk_all;
    logic [NUM_GROUPS-1:0] pend_vec;
    logic [NUM_GROUPS-1:0] clr_vec;
    logic [NUM_GROUPS-1:0] mwe_vec;

    reg_kind_e         kind;
    logic [GIDX_W-1:0] gidx;
    logic              rd_fire;
    logic              wr_fire;
    logic [7:0]        rd_mux;
    logic [7:0]        rdata_q;
    logic              irq_q;

    acc_state_e state_q;
    acc_state_e state_d;

    evt_sync #(.WIDTH(NLINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (evt_in),
        .level_o (lvl_all),
        .rise_o  (rise_all)
    );

    evt_reg_decode #(
        .NUM_GROUPS (NUM_GROUPS),
        .GIDX_W     (GIDX_W),
        .INT_BANK   (INT_BANK),
        .MISC_BANK  (MISC_BANK),
        .LIVE_BASE  (0),
        .STKY_BASE  (32),
        .MASK_BASE  (64),
        .REV_OFF    (8'h80)
    ) u_dec (
        .addr_i (reg_addr),
        .kind_o (kind),
        .gidx_o (gidx)
    );

    assign rd_fire = reg_req & ~reg_wr;
    assign wr_fire = reg_req &  reg_wr;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign clr_vec[g] = rd_fire && kind == RK_STICKY && gidx == GIDX_W'(g);
        assign mwe_vec[g] = wr_fire && kind == RK_MASK   && gidx == GIDX_W'(g);

        evt_irq_group #(.LINES(GRP_LINES)) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .rise_i    (rise_all[g*GRP_LINES +: GRP_LINES]),
            .clr_i     (clr_vec[g]),
            .mask_we_i (mwe_vec[g]),
            .mask_d_i  (reg_wdata),
            .sticky_o  (lat_all[g*GRP_LINES +: GRP_LINES]),
            .mask_o    (msk_all[g*GRP_LINES +: GRP_LINES]),
            .pend_o    (pend_vec[g])
        );
    end

    // Read data selection
    always_comb begin
        rd_mux = '0;
        unique case (kind)
            RK_LIVE:   rd_mux = lvl_all[gidx*GRP_LINES +: GRP_LINES];
            RK_STICKY: rd_mux = lat_all[gidx*GRP_LINES +: GRP_LINES];
            RK_MASK:   rd_mux = msk_all[gidx*GRP_LINES +: GRP_LINES];
            RK_REV:    rd_mux = REV_ID;
            RK_NONE:   rd_mux = '0;
            default:   rd_mux = '0;
        endcase
    end

    // Access sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ACC_IDLE;
        else
            state_q <= state_d;
    end

    // Access sequencer: transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE:  if (rd_fire) state_d = ACC_REPLY;
            ACC_REPLY: state_d = rd_fire ? ACC_REPLY : ACC_IDLE;
            default:   state_d = ACC_IDLE;
        endcase
    end

    // Access sequencer: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_fire)
            rdata_q <= rd_mux;
        else
            rdata_q <= '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |pend_vec;
    end

    assign reg_rvalid = (state_q == ACC_REPLY);
    assign reg_rdata  = rdata_q;
    assign irq_out    = irq_q;
endmodule

// File: rtl/evt_irq_hub_chk.sv
module evt_irq_hub_chk #(
    parameter int unsigned NLINES    = 104,
    parameter logic [7:0]  INT_BANK  = 8'h0E,
    parameter logic [7:0]  MISC_BANK = 8'h10,
    parameter logic [7:0]  REV_ID    = 8'h10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_req,
    input logic              reg_wr,
    input logic [15:0]       reg_addr,
    input logic [7:0]        reg_rdata,
    input logic              reg_rvalid,
    input logic              irq_out,
    input logic [NLINES-1:0] lat_all,
    input logic [NLINES-1:0] msk_all
);
    logic rd;
    logic sticky_rd;
    logic foreign;

    assign rd        = reg_req && !reg_wr;
    assign sticky_rd = rd && reg_addr[15:8] == INT_BANK && reg_addr[7:5] == 3'b001;
    assign foreign   = reg_addr[15:8] != INT_BANK && reg_addr[15:8] != MISC_BANK;

    p_rvalid_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> reg_rvalid);

    p_no_spurious_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !reg_rvalid);

    p_foreign_bank_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && foreign) |=> reg_rdata == 8'h00);

    p_revision_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && reg_addr == {MISC_BANK, 8'h80}) |=> reg_rdata == REV_ID);

    p_all_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (&msk_all) |=> !irq_out);

    p_sticky_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sticky_rd |=> ((lat_all & $past(lat_all)) == $past(lat_all)));
endmodule

bind evt_irq_hub evt_irq_hub_chk #(
    .NLINES    (NUM_GROUPS * 8),
    .INT_BANK  (INT_BANK),
    .MISC_BANK (MISC_BANK),
    .REV_ID    (REV_ID)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_req    (reg_req),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .irq_out    (irq_out),
    .lat_all    (lat_all),
    .msk_all    (msk_all)
);

// File: tb/evt_irq_hub_test.sv
module evt_irq_hub_test;
    localparam int NG = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NG*8-1:0] evt_in = '0;
    logic          reg_req = 1'b0;
    logic          reg_wr = 1'b0;
    logic [15:0]   reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          reg_rvalid;
    logic          irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    evt_irq_hub uut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .irq_out(irq_out)
    );

    // {address, expected} read right after reset
    localparam logic [23:0] RST_TBL [10] = '{
        {16'h0E40, 8'hFF},  // R4 mask of group 0
        {16'h0E45, 8'h00},  // R2 skipped offset 5
        {16'h0E46, 8'hFF},  // R2 group 5 at offset 6
        {16'h0E55, 8'hFF},  // R2 group 12 at offset 21
        {16'h0E56, 8'h00},  // R2 offset 22 unused
        {16'h0E20, 8'h00},  // R6 sticky empty
        {16'h0E00, 8'h00},  // R9 live low
        {16'h1080, 8'h10},  // R10 revision
        {16'h0380, 8'h00},  // R10 foreign bank
        {16'h1081, 8'h00}   // R10 other misc offset
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic v);
        @(negedge clk);
        reg_req = 1'b1; reg_wr = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_req = 1'b0;
        d = reg_rdata; v = reg_rvalid;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_req = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic v;
        idle(3);
        chk("R11 reset rvalid", {7'd0, reg_rvalid}, 8'h00);
        chk("R11 reset irq", {7'd0, irq_out}, 8'h00);
        chk("R11 reset rdata", reg_rdata, 8'h00);
        rst_n = 1'b1;
        idle(2);

        for (int i = 0; i < 10; i++) begin
            rd(RST_TBL[i][23:8], d, v);
            chk($sformatf("R2/R4/R10 table %0d", i), d, RST_TBL[i][7:0]);
        end

        // R11 valid timing
        rd(16'h1080, d, v);
        chk("R11 rvalid after read", {7'd0, v}, 8'h01);
        @(negedge clk);
        chk("R11 rvalid drops", {7'd0, reg_rvalid}, 8'h00);

        // R1 R4 mask write/readback
        wr(16'h0E40, 8'h5A);
        rd(16'h0E40, d, v);
        chk("R1 mask readback", d, 8'h5A);
        wr(16'h0E40, 8'hFF);

        // R3 R5 line 13 -> group 1 bit 5, pulse then low
        evt_in[13] = 1'b1; idle(4);
        evt_in[13] = 1'b0; idle(4);
        rd(16'h0E21, d, v);
        chk("R5 R3 sticky after low", d, 8'h20);
        rd(16'h0E21, d, v);
        chk("R6 cleared by read", d, 8'h00);

        // R9 line 40 -> group 5 (offset 6) bit 0
        evt_in[40] = 1'b1; idle(4);
        rd(16'h0E06, d, v);
        chk("R9 live level", d, 8'h01);
        wr(16'h0E06, 8'hFF);
        rd(16'h0E06, d, v);
        chk("R9 live write ignored", d, 8'h01);
        wr(16'h0E26, 8'h00);
        rd(16'h0E26, d, v);
        chk("R9 sticky write ignored", d, 8'h01);
        evt_in[40] = 1'b0;

        // R2 writes to skipped offsets ignored
        wr(16'h0E45, 8'h00);
        rd(16'h0E45, d, v);
        chk("R2 skipped write", d, 8'h00);
        rd(16'h0E17, d, v);
        chk("R2 offset 23 live", d, 8'h00);

        // R4 R8 line 100 -> group 12 (offset 21) bit 4
        evt_in[100] = 1'b1; idle(5);
        chk("R4 masked no irq", {7'd0, irq_out}, 8'h00);
        wr(16'h0E55, 8'hEF);
        idle(2);
        chk("R8 irq raised", {7'd0, irq_out}, 8'h01);
        rd(16'h0E35, d, v);
        chk("R6 sticky group 12", d, 8'h10);
        idle(2);
        chk("R8 irq drops after ack", {7'd0, irq_out}, 8'h00);
        evt_in[100] = 1'b0;

        // R7 edge in the same cycle as the sticky read
        evt_in[1] = 1'b1; idle(4);
        @(negedge clk);
        evt_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_req = 1'b1; reg_wr = 1'b0; reg_addr = 16'h0E20;
        @(negedge clk);
        reg_req = 1'b0;
        chk("R7 first read", reg_rdata, 8'h02);
        rd(16'h0E20, d, v);
        chk("R7 edge survives clear", d, 8'h01);

        finish_run();
    end
endmodule